// File: doc/BRIEF.md
# Accumulator Round and Saturate Extractor

This unit turns the contents of a pair of 40-bit accumulators into a rounded and saturated 32-bit result, delivered as a high and a low 16-bit word for a register pair. The working value puts the first accumulator in the upper part and takes only the bottom 16 bits of the second accumulator. That value is scaled by a signed 3-bit shift code. A rounding constant of one half is then added at bit 15, and the low 16 bits are dropped. A result outside the signed 32-bit range is clamped to a fixed code for each direction.

A request is a one-cycle `start` strobe. The strobe comes with the two accumulator values, the shift code and the source-accumulator select. Only the first accumulator is a legal source. Any other select raises `illegal_op` for one cycle and leaves the results and flags untouched. The unit keeps two status flags. On every legal request the old primary flag moves into the secondary flag, and the primary flag records whether the new result was clamped. Writing the words back to a register file is left to the surrounding logic.

Top module: `acc_rnd_extract`

## Requirements
- R1: A strobe with `acc_sel` not equal to 0 raises `illegal_op` in the next cycle and `res_valid` stays low. `res_hi`, `res_lo`, `flag0` and `flag1` keep their values.
- R2: The working value is `a0_val` (sign bit 39) multiplied by 65536 plus `a1_val[15:0]`. Bits 39:16 of `a1_val` have no effect.
- R3: `shift_code` is two's complement. Codes 0 to 3 shift the working value left by that many bits. Codes 4 to 7 (that is, -4 to -1) shift it right arithmetically by 4 to 1 bits.
- R4: After the shift, 32768 is added and the sum is shifted right arithmetically by 16. An in-range result is output with bits 31:16 on `res_hi` and bits 15:0 on `res_lo`.
- R5: A result above 2147483647 gives `res_hi` = 0x7FFF and `res_lo` = 0xFFFF.
- R6: A result below -2147483648 gives `res_hi` = 0x8000 and `res_lo` = 0x0000.
- R7: On each legal request, `flag1` takes the value `flag0` had before that request.
- R8: On each legal request, `flag0` becomes 1 if the result was clamped (R5 or R6) and 0 otherwise.
- R9: `res_valid` is high for exactly the one cycle after a legal strobe. Without a strobe, the results and flags hold their values.
- R10: Synchronous reset clears `res_hi`, `res_lo`, `flag0`, `flag1`, `res_valid` and `illegal_op` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| acc_sel | input | 1 | Source accumulator select; only 0 is legal |
| a0_val | input | 40 | First accumulator, upper part of the working value |
| a1_val | input | 40 | Second accumulator; only bits 15:0 are used |
| shift_code | input | 3 | Signed shift amount, -4 to +3 |
| res_hi | output | 16 | Result bits 31:16 or the clamp code |
| res_lo | output | 16 | Result bits 15:0 or the clamp code |
| flag0 | output | 1 | Primary flag: the last legal result was clamped |
| flag1 | output | 1 | Secondary flag: previous primary flag |
| res_valid | output | 1 | Result updated this cycle |
| illegal_op | output | 1 | Last strobe selected an illegal source |

## Verification
The properties assume that `start`, `acc_sel` and the operands are known and stable around the rising edge. They also assume that reset is held for at least one edge before the first strobe. This keeps the one-cycle-back references to the strobe meaningful. The stimulus changes inputs only on the falling edge and keeps `start` low while reset is asserted. It also issues back-to-back strobes, so that the flag hand-over from one request to the next is covered alongside requests with idle gaps between them.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;

    localparam int ACC_WIDTH   = 40;
    localparam int HALF_WIDTH  = 16;
    localparam int SHIFT_WIDTH = 3;
    localparam int SEL_WIDTH   = 1;

    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_POS  = 2'd1,
        SAT_NEG  = 2'd2
    } sat_kind_e;

    // magnitude of a two's complement shift code
    function automatic logic [SHIFT_WIDTH-1:0] code_mag(input logic [SHIFT_WIDTH-1:0] code);
        return code[SHIFT_WIDTH-1] ? (~code + SHIFT_WIDTH'(1)) : code;
    endfunction

endpackage

// File: rtl/acc_join_shift.sv
module acc_join_shift
    import acc_rnd_pkg::*;
#(
    parameter int ACC_W  = ACC_WIDTH,
    parameter int HALF_W = HALF_WIDTH,
    parameter int SH_W   = SHIFT_WIDTH,
    parameter int WORK_W = ACC_W + HALF_W + (1 << (SH_W - 1))
) (
    input  logic [ACC_W-1:0]         hi_acc,
    input  logic [ACC_W-1:0]         lo_acc,
    input  logic [SH_W-1:0]          code,
    output logic signed [WORK_W-1:0] shifted
);
    localparam int EXT_W = WORK_W - ACC_W - HALF_W;

    logic signed [WORK_W-1:0] joined;
    logic [SH_W-1:0]          mag;

    always_comb begin
        joined = {{EXT_W{hi_acc[ACC_W-1]}}, hi_acc, lo_acc[HALF_W-1:0]};
        mag    = code_mag(code);
        if (code[SH_W-1]) begin
            shifted = joined >>> mag;
        end else begin
            shifted = joined <<< mag;
        end
    end
endmodule

// File: rtl/acc_round_sat.sv
module acc_round_sat
    import acc_rnd_pkg::*;
#(
    parameter int HALF_W = HALF_WIDTH,
    parameter int WORK_W = 60
) (
    input  logic signed [WORK_W-1:0] shifted,
    output logic [HALF_W-1:0]        word_hi,
    output logic [HALF_W-1:0]        word_lo,
    output sat_kind_e                kind
);
    localparam int RND_W = WORK_W - HALF_W;
    localparam int RES_W = 2 * HALF_W;
    localparam logic signed [WORK_W-1:0] HALF_LSB = {{(WORK_W-1){1'b0}}, 1'b1} << (HALF_W - 1);

    logic signed [WORK_W-1:0] sum;
    logic signed [WORK_W-1:0] scaled;
    logic [RND_W-1:0]         rounded;
    logic [RND_W-RES_W:0]     top_bits;

    always_comb begin
        sum      = shifted + HALF_LSB;
        scaled   = sum >>> HALF_W;
        rounded  = scaled[RND_W-1:0];
        top_bits = rounded[RND_W-1:RES_W-1];
        if (!rounded[RND_W-1] && (|top_bits)) begin
            kind    = SAT_POS;
            word_hi = {1'b0, {(HALF_W-1){1'b1}}};
            word_lo = {HALF_W{1'b1}};
        end else if (rounded[RND_W-1] && !(&top_bits)) begin
            kind    = SAT_NEG;
            word_hi = {1'b1, {(HALF_W-1){1'b0}}};
            word_lo = {HALF_W{1'b0}};
        end else begin
            kind    = SAT_NONE;
            word_hi = rounded[RES_W-1:HALF_W];
            word_lo = rounded[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/acc_rnd_extract.sv
module acc_rnd_extract
    import acc_rnd_pkg::*;
#(
    parameter int ACC_W  = ACC_WIDTH,
    parameter int HALF_W = HALF_WIDTH,
    parameter int SH_W   = SHIFT_WIDTH,
    parameter int SEL_W  = SEL_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [ACC_W-1:0]  a0_val,
    input  logic [ACC_W-1:0]  a1_val,
    input  logic [SH_W-1:0]   shift_code,
    output logic [HALF_W-1:0] res_hi,
    output logic [HALF_W-1:0] res_lo,
    output logic              flag0,
    output logic              flag1,
    output logic              res_valid,
    output logic              illegal_op
);
    localparam int WORK_W = ACC_W + HALF_W + (1 << (SH_W - 1));

    logic signed [WORK_W-1:0] shifted;
    logic [HALF_W-1:0]        nxt_hi;
    logic [HALF_W-1:0]        nxt_lo;
    sat_kind_e                nxt_kind;
    logic                     legal;

    assign legal = (acc_sel == '0);

    acc_join_shift #(
        .ACC_W (ACC_W),
        .HALF_W(HALF_W),
        .SH_W  (SH_W),
        .WORK_W(WORK_W)
    ) u_join (
        .hi_acc (a0_val),
        .lo_acc (a1_val),
        .code   (shift_code),
        .shifted(shifted)
    );

    acc_round_sat #(
        .HALF_W(HALF_W),
        .WORK_W(WORK_W)
    ) u_rsat (
        .shifted(shifted),
        .word_hi(nxt_hi),
        .word_lo(nxt_lo),
        .kind   (nxt_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_hi     <= '0;
            res_lo     <= '0;
            flag0      <= 1'b0;
            flag1      <= 1'b0;
            res_valid  <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            res_valid  <= start && legal;
            illegal_op <= start && !legal;
            if (start && legal) begin
                res_hi <= nxt_hi;
                res_lo <= nxt_lo;
                flag1  <= flag0;
                flag0  <= (nxt_kind != SAT_NONE);
            end
        end
    end
endmodule

// File: rtl/acc_rnd_extract_chk.sv
module acc_rnd_extract_chk #(
    parameter int HALF_W = 16,
    parameter int SEL_W  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [SEL_W-1:0]  acc_sel,
    input logic [HALF_W-1:0] res_hi,
    input logic [HALF_W-1:0] res_lo,
    input logic              flag0,
    input logic              flag1,
    input logic              res_valid,
    input logic              illegal_op
);
    p_illegal_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (start && acc_sel != '0) |=> (illegal_op && !res_valid && $stable(res_hi)
            && $stable(res_lo) && $stable(flag0) && $stable(flag1)));

    p_pos_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && flag0 && !res_hi[HALF_W-1]) |->
            (res_hi == {1'b0, {(HALF_W-1){1'b1}}} && res_lo == {HALF_W{1'b1}}));

    p_neg_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && flag0 && res_hi[HALF_W-1]) |->
            (res_hi == {1'b1, {(HALF_W-1){1'b0}}} && res_lo == '0));

    p_flag_move_r7: assert property (@(posedge clk) disable iff (rst)
        (start && acc_sel == '0) |=> (flag1 == $past(flag0)));

    p_valid_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        (start && acc_sel == '0) |=> res_valid);

    p_valid_needs_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(start));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(res_hi) && $stable(res_lo) && $stable(flag0) && $stable(flag1)));

    p_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && illegal_op));
endmodule

bind acc_rnd_extract acc_rnd_extract_chk #(
    .HALF_W(HALF_W),
    .SEL_W (SEL_W)
) u_chk (.*);

// File: tb/test_acc_rnd_extract.sv
module test_acc_rnd_extract;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [0:0]  acc_sel = '0;
    logic [39:0] a0_val = '0;
    logic [39:0] a1_val = '0;
    logic [2:0]  shift_code = '0;
    logic [15:0] res_hi;
    logic [15:0] res_lo;
    logic        flag0, flag1, res_valid, illegal_op;

    int total = 0;
    int bad   = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    acc_rnd_extract i_acc_rnd_extract (
        .clk(clk), .rst(rst), .start(start), .acc_sel(acc_sel),
        .a0_val(a0_val), .a1_val(a1_val), .shift_code(shift_code),
        .res_hi(res_hi), .res_lo(res_lo), .flag0(flag0), .flag1(flag1),
        .res_valid(res_valid), .illegal_op(illegal_op)
    );

    // behavioural reference state
    logic [15:0] m_hi = '0, m_lo = '0;
    logic        m_f0 = 0, m_f1 = 0, m_valid = 0, m_ill = 0;
    string       m_tag = "R10";
    bit          m_ready = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint ref_round(input logic [39:0] a0, input logic [39:0] a1, input logic [2:0] code);
        longint w;
        int     sc;
        w  = longint'({{24{a0[39]}}, a0}) * 65536 + longint'({48'd0, a1[15:0]});
        sc = (code >= 3'd4) ? int'(code) - 8 : int'(code);
        if (sc >= 0) w = w <<< sc;
        else         w = w >>> (-sc);
        return (w + 32768) >>> 16;
    endfunction

    always @(posedge clk) begin
        longint r;
        if (rst) begin
            m_hi = '0; m_lo = '0; m_f0 = 0; m_f1 = 0; m_valid = 0; m_ill = 0;
            m_tag = "R10";
            m_ready = 1;
        end else begin
            m_valid = start && (acc_sel == 1'b0);
            m_ill   = start && (acc_sel != 1'b0);
            if (m_valid) begin
                r = ref_round(a0_val, a1_val, shift_code);
                m_f1 = m_f0;
                if (r > 64'sd2147483647) begin
                    m_hi = 16'h7FFF; m_lo = 16'hFFFF; m_f0 = 1; m_tag = "R5";
                end else if (r < -64'sd2147483648) begin
                    m_hi = 16'h8000; m_lo = 16'h0000; m_f0 = 1; m_tag = "R6";
                end else begin
                    m_hi = r[31:16]; m_lo = r[15:0]; m_f0 = 0; m_tag = "R4";
                end
            end else if (m_ill) begin
                m_tag = "R1";
            end else begin
                m_tag = "R9";
            end
        end
    end

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (m_ready && !done_run) begin
            chk(res_hi == m_hi, m_tag, res_hi, m_hi);
            chk(res_lo == m_lo, m_tag, res_lo, m_lo);
            chk(flag0 == m_f0, "R8", flag0, m_f0);
            chk(flag1 == m_f1, "R7", flag1, m_f1);
            chk(res_valid == m_valid, "R9", res_valid, m_valid);
            chk(illegal_op == m_ill, "R1", illegal_op, m_ill);
        end
    end

    task automatic issue(input logic sel, input logic [39:0] a0, input logic [39:0] a1, input logic [2:0] code);
        @(negedge clk);
        start = 1; acc_sel = sel; a0_val = a0; a1_val = a1; shift_code = code;
        @(negedge clk);
        start = 0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state at the ports
        chk(res_hi == 0 && res_lo == 0 && !flag0 && !flag1 && !res_valid && !illegal_op,
            "R10", {res_hi, res_lo}, 0);
        rst = 0;

        // R2: upper bits of a1 ignored, R4 rounding below the half point
        issue(0, 40'h00_0000_0001, 40'hAB_CDEF_7FFF, 3'd0);
        chk({res_hi, res_lo} == 32'h0000_0001, "R2", {res_hi, res_lo}, 32'h1);
        // R4: exactly one half rounds up
        issue(0, 40'h00_0000_0001, 40'h00_0000_8000, 3'd0);
        chk({res_hi, res_lo} == 32'h0000_0002, "R4", {res_hi, res_lo}, 32'h2);
        // R3: left by one
        issue(0, 40'h00_0001_0000, 40'h0, 3'd1);
        chk({res_hi, res_lo} == 32'h0002_0000, "R3", {res_hi, res_lo}, 32'h20000);
        // R3: code 7 means right by one
        issue(0, 40'h00_0001_0000, 40'h0, 3'd7);
        chk({res_hi, res_lo} == 32'h0000_8000, "R3", {res_hi, res_lo}, 32'h8000);
        // R3: code 4 means arithmetic right by four on a negative value
        issue(0, 40'hFF_FFFF_0000, 40'h0, 3'd4);
        chk({res_hi, res_lo} == 32'hFFFF_F000, "R3", {res_hi, res_lo}, 32'hFFFFF000);
        // R8: largest in-range value is not clamped
        issue(0, 40'h00_7FFF_FFFF, 40'h00_0000_7FFF, 3'd0);
        chk({res_hi, res_lo} == 32'h7FFF_FFFF && !flag0, "R8", {flag0, res_hi, res_lo}, 32'h7FFFFFFF);
        // R5: rounding carries past the maximum
        issue(0, 40'h00_7FFF_FFFF, 40'h00_0000_8000, 3'd0);
        chk({res_hi, res_lo} == 32'h7FFF_FFFF && flag0, "R5", {flag0, res_hi, res_lo}, 33'h17FFFFFFF);
        // R1: illegal select leaves everything as it was
        issue(1, 40'h00_0000_0005, 40'h0, 3'd0);
        chk({res_hi, res_lo} == 32'h7FFF_FFFF && flag0 && illegal_op, "R1", {res_hi, res_lo}, 32'h7FFFFFFF);
        // R6: one below the minimum
        issue(0, 40'hFF_7FFF_FFFF, 40'h0, 3'd0);
        chk({res_hi, res_lo} == 32'h8000_0000 && flag0, "R6", {res_hi, res_lo}, 32'h80000000);
        // R7: next normal request moves the set flag into flag1
        issue(0, 40'h00_0000_0003, 40'h0, 3'd0);
        chk(flag1 && !flag0, "R7", {flag1, flag0}, 2'b10);

        // back-to-back and mixed requests against the reference
        for (int i = 0; i < 3000; i++) begin
            logic [39:0] a0;
            int k;
            k = $urandom_range(0, 3);
            case (k)
                0: a0 = {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
                1: a0 = 40'h00_7FFF_0000 + 40'($urandom_range(0, 131071));
                2: a0 = 40'hFF_8000_0000 - 40'($urandom_range(0, 65535));
                default: a0 = {{20{$urandom_range(0, 1) == 1}}, 20'($urandom())};
            endcase
            @(negedge clk);
            start = ($urandom_range(0, 3) != 0);
            acc_sel = ($urandom_range(0, 7) == 0);
            a0_val = a0;
            a1_val = {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
            shift_code = 3'($urandom());
        end
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        done_run = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            done_run = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule